// File: doc/BRIEF.md
# One-Time-Programmable Word Array Controller

This block fronts a one-time-programmable array of 32-bit words with a small 32-bit register bus. Software loads a command word holding a word index, a burst length and an opcode. It then writes 1 to a start register. The controller then runs one of two operations on its own:
- a burst read of up to eight consecutive words into a bank of read-back registers;
- a single-word program that can only turn bits from 0 to 1.

Each program operation first reads the target word and then writes the new bits. It then reads the word back and checks it against the old value ORed with the new bits. Completion and failure are reported in a write-one-to-clear status register. That register also carries a read-only busy flag, so software can poll it.

The array is a synthesizable register model. Every access takes a configurable number of cycles, ACC_LAT, which defaults to 4. One word index can be given a set of bits that never program (STUCK_IDX and STUCK_MASK). This models a defective cell and gives the verify check something to catch. Requests are checked before they are accepted. A malformed request raises an error flag and leaves both the array and the read-back registers untouched.

Top module: `otp_regctl`

## Requirements
- R1: After reset every readable register reads 0, and every array word reads back as 0.
- R2: Register offsets:

  | Offset | Register | Access |
  |---|---|---|
  | 0x04 | command | read/write |
  | 0x08 | start | reads 0 |
  | 0x10 | program data | read/write |
  | 0x84 | status | see R4 and R9 |

  The command fields are: word index in bits [31:16], burst count in bits [15:8], opcode in bits [1:0] (0 = read, 2 = program). Bits [7:2] are ignored.
- R3: Writing 1 to bit 0 of offset 0x08 while idle with a valid read command copies `count` words, starting at `index`, into the read-back registers at 0x20 + 4*i. Read-back registers at i >= count keep their values. Busy falls, and status bit 1 (read done) is set, on the clock edge count*ACC_LAT after the start edge.
- R4: Status bit 0 reads 1 from the start edge until completion and ignores writes.
- R5: The following requests each set status bit 4 (error) on the start edge, never raise busy, and leave the array and the read-back registers unchanged:
  - a read with count 0;
  - a read with count above 8;
  - a read whose index + count exceeds 0x300;
  - a program whose index is 0x300 or higher;
  - any opcode other than 0 or 2.
- R6: A program ORs the program data into the stored word, so bits already 1 stay 1. The count field is ignored. On success, status bit 3 (program done) is set when busy falls, 3*ACC_LAT edges after the start edge.
- R7: If the word read back after a program differs from the old value ORed with the program data, status bit 2 (verify failure) is set instead of bit 3.
- R8: A start written while busy is ignored. The running operation completes unchanged, and no second operation follows it.
- R9: Writing 1 to status bits 4..1 clears them, and writing 0 leaves them. If a bit is set and cleared on the same edge, the set wins.
- R10: The command and program-data values are captured on the start edge. Writing either register during an operation does not change that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The completion of an operation and a software clear of the status register can fall on the same clock edge. The bench provokes this by counting edges from the start of a two-word read. It places a write of 1 to the read-done bit exactly on the edge where busy falls, and then requires that the bit reads back as 1. A second case issues a new start and a changed command while the controller is busy. It then requires that only the first operation's results appear.

// File: rtl/otp_regctl_pkg.sv
package otp_regctl_pkg;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned ADR_W = 8;

  // register byte offsets
  localparam logic [ADR_W-1:0] OFS_CMD  = 8'h04;
  localparam logic [ADR_W-1:0] OFS_GO   = 8'h08;
  localparam logic [ADR_W-1:0] OFS_PDAT = 8'h10;
  localparam logic [ADR_W-1:0] OFS_DOUT = 8'h20;
  localparam logic [ADR_W-1:0] OFS_STAT = 8'h84;

  localparam logic [1:0] OPC_READ = 2'd0;
  localparam logic [1:0] OPC_PROG = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD,
    SQ_PRD,
    SQ_PWR,
    SQ_PVF
  } sq_state_t;

  // packed so that bit 0 lands on status bit 1
  typedef struct packed {
    logic err;
    logic pdone;
    logic vfail;
    logic rdone;
  } sq_evt_t;

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int unsigned WORDS   = 768,
  parameter int unsigned DW      = 32,
  parameter int unsigned ACC_LAT = 4,
  parameter int unsigned STUCK_IDX = 0,
  parameter logic [DW-1:0] STUCK_MASK = '0,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned LC_W  = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic             ack,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem_q [WORDS];
  logic [LC_W-1:0] lat_q, lat_d;
  logic [DW-1:0] hold_mask;
  logic mem_en;

  always_comb begin
    ack   = req && (lat_q == LC_W'(ACC_LAT - 1));
    lat_d = lat_q;
    if (!req || ack) begin
      lat_d = '0;
    end else begin
      lat_d = lat_q + LC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else begin
      lat_q <= lat_d;
    end
  end

  // defective cells never program
  assign hold_mask = (idx == IDX_W'(STUCK_IDX)) ? STUCK_MASK : '0;
  assign mem_en    = ack && wr;
  assign rdata     = mem_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < int'(WORDS); w++) begin
        mem_q[w] <= '0;
      end
    end else if (mem_en) begin
      mem_q[idx] <= mem_q[idx] | (wdata & ~hold_mask);
    end
  end

endmodule

// File: rtl/otp_burst_seq.sv
module otp_burst_seq
  import otp_regctl_pkg::*;
#(
  parameter int unsigned WORDS     = 768,
  parameter int unsigned BURST_MAX = 8,
  localparam int unsigned IDX_W  = $clog2(WORDS),
  localparam int unsigned BEAT_W = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BUS_W-1:0]  cmd,
  input  logic [BUS_W-1:0]  pdata,
  output logic              busy,
  output logic              arr_req,
  output logic              arr_wr,
  output logic [IDX_W-1:0]  arr_idx,
  output logic [BUS_W-1:0]  arr_wdata,
  input  logic              arr_ack,
  input  logic [BUS_W-1:0]  arr_rdata,
  output logic              cap_en,
  output logic [BEAT_W-1:0] cap_sel,
  output logic [BUS_W-1:0]  cap_data,
  output sq_evt_t           evt
);

  sq_state_t state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BEAT_W-1:0] last_q, last_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BUS_W-1:0]  pdat_q, pdat_d;
  logic [BUS_W-1:0]  old_q, old_d;

  logic [15:0] f_idx;
  logic [7:0]  f_cnt;
  logic [1:0]  f_op;
  logic [16:0] f_end;
  logic rd_ok, pg_ok;
  logic unused_cmd_bits;

  assign f_idx = cmd[31:16];
  assign f_cnt = cmd[15:8];
  assign f_op  = cmd[1:0];
  assign unused_cmd_bits = ^cmd[7:2];
  assign f_end = {1'b0, f_idx} + {9'b0, f_cnt};

  assign rd_ok = (f_op == OPC_READ) && (f_cnt != 8'd0) &&
                 (f_cnt <= 8'(BURST_MAX)) && (f_end <= 17'(WORDS));
  assign pg_ok = (f_op == OPC_PROG) && (f_idx < 16'(WORDS));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    beat_d  = beat_q;
    pdat_d  = pdat_q;
    old_d   = old_q;
    evt     = '0;
    cap_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (rd_ok) begin
            state_d = SQ_RD;
            idx_d   = f_idx[IDX_W-1:0];
            last_d  = BEAT_W'(f_cnt - 8'd1);
            beat_d  = '0;
          end else if (pg_ok) begin
            state_d = SQ_PRD;
            idx_d   = f_idx[IDX_W-1:0];
            beat_d  = '0;
            pdat_d  = pdata;
          end else begin
            evt.err = 1'b1;
          end
        end
      end
      SQ_RD: begin
        if (arr_ack) begin
          cap_en = 1'b1;
          if (beat_q == last_q) begin
            state_d   = SQ_IDLE;
            evt.rdone = 1'b1;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      SQ_PRD: begin
        if (arr_ack) begin
          old_d   = arr_rdata;
          state_d = SQ_PWR;
        end
      end
      SQ_PWR: begin
        if (arr_ack) begin
          state_d = SQ_PVF;
        end
      end
      SQ_PVF: begin
        if (arr_ack) begin
          state_d = SQ_IDLE;
          if (arr_rdata == (old_q | pdat_q)) begin
            evt.pdone = 1'b1;
          end else begin
            evt.vfail = 1'b1;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      beat_q  <= '0;
      pdat_q  <= '0;
      old_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      beat_q  <= beat_d;
      pdat_q  <= pdat_d;
      old_q   <= old_d;
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign arr_req   = busy;
  assign arr_wr    = (state_q == SQ_PWR);
  assign arr_idx   = idx_q + IDX_W'(beat_q);
  assign arr_wdata = old_q | pdat_q;
  assign cap_sel   = beat_q;
  assign cap_data  = arr_rdata;

endmodule

// File: rtl/otp_regbank.sv
module otp_regbank
  import otp_regctl_pkg::*;
#(
  parameter int unsigned BURST_MAX = 8,
  localparam int unsigned BEAT_W = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [BUS_W-1:0]  cmd_q,
  output logic [BUS_W-1:0]  pdat_q,
  output logic              start,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [BEAT_W-1:0] cap_sel,
  input  logic [BUS_W-1:0]  cap_data,
  input  sq_evt_t           evt
);

  logic cmd_we, pdat_we, stat_we;
  sq_evt_t st_q, st_d, st_clr;
  logic [BUS_W-1:0] dout_w [BURST_MAX];
  logic [ADR_W-1:0] dofs;
  logic dout_hit;

  assign cmd_we  = bus_we && (bus_addr == OFS_CMD);
  assign pdat_we = bus_we && (bus_addr == OFS_PDAT);
  assign stat_we = bus_we && (bus_addr == OFS_STAT);
  assign start   = bus_we && (bus_addr == OFS_GO) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_we) begin
      cmd_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdat_q <= '0;
    end else if (pdat_we) begin
      pdat_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < int'(BURST_MAX); g++) begin : g_dout
    logic [BUS_W-1:0] word_q;
    logic word_en;
    assign word_en = cap_en && (cap_sel == BEAT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= cap_data;
      end
    end
    assign dout_w[g] = word_q;
  end

  // events take priority over a clear on the same edge
  always_comb begin
    st_clr = stat_we ? sq_evt_t'(bus_wdata[4:1]) : '0;
    st_d   = (st_q & ~st_clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign dofs     = bus_addr - OFS_DOUT;
  assign dout_hit = (bus_addr >= OFS_DOUT) && (dofs[1:0] == 2'b00) &&
                    (dofs[ADR_W-1:2] < (ADR_W-2)'(BURST_MAX));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CMD) begin
      bus_rdata = cmd_q;
    end else if (bus_addr == OFS_PDAT) begin
      bus_rdata = pdat_q;
    end else if (bus_addr == OFS_STAT) begin
      bus_rdata = {27'd0, st_q, busy};
    end else if (dout_hit) begin
      bus_rdata = dout_w[BEAT_W'(dofs[ADR_W-1:2])];
    end
  end

endmodule

// File: rtl/otp_regctl.sv
module otp_regctl
  import otp_regctl_pkg::*;
#(
  parameter int unsigned WORDS     = 768,
  parameter int unsigned BURST_MAX = 8,
  parameter int unsigned ACC_LAT   = 4,
  parameter int unsigned STUCK_IDX = 0,
  parameter logic [31:0] STUCK_MASK = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int unsigned IDX_W  = $clog2(WORDS);
  localparam int unsigned BEAT_W = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1;

  logic [1:0] rs_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  logic [BUS_W-1:0]  cmd_q, pdat_q;
  logic              start, busy, cap_en;
  logic [BEAT_W-1:0] cap_sel;
  logic [BUS_W-1:0]  cap_data;
  sq_evt_t           evt;
  logic              arr_req, arr_wr, arr_ack;
  logic [IDX_W-1:0]  arr_idx;
  logic [BUS_W-1:0]  arr_wdata, arr_rdata;

  otp_regbank #(.BURST_MAX(BURST_MAX)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cmd_q    (cmd_q),
    .pdat_q   (pdat_q),
    .start    (start),
    .busy     (busy),
    .cap_en   (cap_en),
    .cap_sel  (cap_sel),
    .cap_data (cap_data),
    .evt      (evt)
  );

  otp_burst_seq #(.WORDS(WORDS), .BURST_MAX(BURST_MAX)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .cmd      (cmd_q),
    .pdata    (pdat_q),
    .busy     (busy),
    .arr_req  (arr_req),
    .arr_wr   (arr_wr),
    .arr_idx  (arr_idx),
    .arr_wdata(arr_wdata),
    .arr_ack  (arr_ack),
    .arr_rdata(arr_rdata),
    .cap_en   (cap_en),
    .cap_sel  (cap_sel),
    .cap_data (cap_data),
    .evt      (evt)
  );

  otp_fuse_array #(
    .WORDS     (WORDS),
    .DW        (BUS_W),
    .ACC_LAT   (ACC_LAT),
    .STUCK_IDX (STUCK_IDX),
    .STUCK_MASK(STUCK_MASK)
  ) u_fuse (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .req  (arr_req),
    .wr   (arr_wr),
    .idx  (arr_idx),
    .wdata(arr_wdata),
    .ack  (arr_ack),
    .rdata(arr_rdata)
  );

endmodule

// File: rtl/otp_regctl_chk.sv
module otp_regctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        start,
  input logic        cap_en,
  input logic [3:0]  evt,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata
);

  // R3: a read-done event ends the operation on that edge
  p_rdone_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> !busy);

  // R3: read-back registers are only written while an operation runs
  p_no_capture_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cap_en);

  // R4: busy flag on the bus matches the sequencer
  p_busy_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h84) |-> (bus_rdata[0] == busy));

  // R5: an error is raised only from idle
  p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt[3] |-> (!busy && start));

  // R7: verify failure and program done never together
  p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt));

  // R8: once busy, the controller stays busy until a completion event
  p_busy_until_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (evt == 4'b0)) |=> busy);

endmodule

bind otp_regctl otp_regctl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .busy     (busy),
  .start    (start),
  .cap_en   (cap_en),
  .evt      (evt),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/otp_regctl_tb_top.sv
`timescale 1ns/1ps
module otp_regctl_tb_top;

  localparam int WORDS = 768;
  localparam int BMAX  = 8;
  localparam int LAT   = 4;
  localparam int SIDX  = 'h2F0;
  localparam logic [31:0] SMASK = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  always #4 clk = ~clk;

  otp_regctl #(
    .WORDS(WORDS), .BURST_MAX(BMAX), .ACC_LAT(LAT),
    .STUCK_IDX(SIDX), .STUCK_MASK(SMASK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mem [WORDS];
  logic [31:0] m_dout [BMAX];
  logic [31:0] m_cmd, m_pdat, p_pd;
  logic [3:0]  m_st;      // [0] read done, [1] verify fail, [2] prog done, [3] error
  bit          m_busy;
  int          m_timer, p_kind, p_idx, p_cnt;

  always @(posedge clk or negedge rst_n) begin : model
    int idx, cnt, op;
    logic [3:0] setv, clrv;
    logic [31:0] oldw, want, got, hold;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 32'h0;
      foreach (m_dout[i]) m_dout[i] = 32'h0;
      m_cmd = 0; m_pdat = 0; m_st = 0; m_busy = 0; m_timer = 0;
      p_kind = 0; p_idx = 0; p_cnt = 0; p_pd = 0;
    end else begin
      setv = 4'b0;
      clrv = 4'b0;
      if (m_busy) begin
        m_timer = m_timer - 1;
        if (m_timer == 0) begin
          m_busy = 0;
          if (p_kind == 1) begin
            for (int i = 0; i < p_cnt; i++) m_dout[i] = m_mem[p_idx + i];
            setv[0] = 1'b1;
          end else begin
            oldw = m_mem[p_idx];
            hold = (p_idx == SIDX) ? SMASK : 32'h0;
            want = oldw | p_pd;
            got  = oldw | (p_pd & ~hold);
            m_mem[p_idx] = got;
            if (got == want) setv[2] = 1'b1; else setv[1] = 1'b1;
          end
        end
      end else if (bus_we && bus_addr == 8'h08 && bus_wdata[0]) begin
        idx = int'(m_cmd >> 16);
        cnt = int'((m_cmd >> 8) & 32'hFF);
        op  = int'(m_cmd & 32'h3);
        if (op == 0 && cnt >= 1 && cnt <= BMAX && idx + cnt <= WORDS) begin
          m_busy = 1; p_kind = 1; p_idx = idx; p_cnt = cnt; m_timer = cnt * LAT;
        end else if (op == 2 && idx < WORDS) begin
          m_busy = 1; p_kind = 2; p_idx = idx; p_pd = m_pdat; m_timer = 3 * LAT;
        end else begin
          setv[3] = 1'b1;
        end
      end
      if (bus_we && bus_addr == 8'h04) m_cmd = bus_wdata;
      if (bus_we && bus_addr == 8'h10) m_pdat = bus_wdata;
      if (bus_we && bus_addr == 8'h84) clrv = bus_wdata[4:1];
      m_st = (m_st & ~clrv) | setv;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    if (a == 8'h04) return m_cmd;
    if (a == 8'h10) return m_pdat;
    if (a == 8'h84) return {27'd0, m_st, m_busy};
    if (a >= 8'h20 && a < 8'h40 && a[1:0] == 2'b00) return m_dout[(a - 8'h20) >> 2];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h84) return "R4";
    if (a >= 8'h20 && a < 8'h40) return "R3";
    if (a == 8'h04 || a == 8'h10) return "R2";
    return "R1";
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done_flag) begin
      if (!(m_busy && bus_addr >= 8'h20 && bus_addr < 8'h40))
        chk(bus_rdata, exp_rd(bus_addr), {tag_of(bus_addr), " per-cycle model"});
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h84; bus_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_addr = 8'h84;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d, e, tag);
  endtask

  task automatic wait_idle();
    int guard = 0;
    bus_addr = 8'h84;
    #1;
    while (bus_rdata[0] && guard < 2000) begin
      @(negedge clk);
      #1;
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] c, input logic [31:0] pd);
    bus_wr(8'h04, c);
    bus_wr(8'h10, pd);
    bus_wr(8'h08, 32'h1);
    wait_idle();
  endtask

  task automatic clr_all();
    bus_wr(8'h84, 32'h1E);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h84; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(8'h84, 32'h0, "R1 status after reset");
    rd_chk(8'h04, 32'h0, "R1 command after reset");
    rd_chk(8'h08, 32'h0, "R1 start reads zero");

    // R2 register layout
    bus_wr(8'h04, 32'h0104_0403);
    rd_chk(8'h04, 32'h0104_0403, "R2 command readback");
    bus_wr(8'h10, 32'hCAFE_F00D);
    rd_chk(8'h10, 32'hCAFE_F00D, "R2 program data readback");

    // R1 blank array, R3 burst read
    run(32'h0104_0400, 32'h0);
    rd_chk(8'h20, 32'h0, "R1 blank word");
    rd_chk(8'h2C, 32'h0, "R1 blank word 3");
    rd_chk(8'h84, 32'h2, "R3 read done only");
    clr_all();
    rd_chk(8'h84, 32'h0, "R9 clear all");

    // R6 program with OR semantics
    run(32'h0104_0002, 32'hA5A5_0000);
    rd_chk(8'h84, 32'h8, "R6 program done");
    clr_all();
    run(32'h0104_0002, 32'h0000_00FF);
    run(32'h0105_0002, 32'h1234_5678);
    run(32'h0104_0002, 32'h0000_0001);
    rd_chk(8'h84, 32'h8, "R6 subset program done");
    clr_all();

    // R3 full burst of 8
    run(32'h0100_0800, 32'h0);
    rd_chk(8'h30, 32'hA5A5_00FF, "R6 ORed word in burst");
    rd_chk(8'h34, 32'h1234_5678, "R3 burst word 5");
    rd_chk(8'h20, 32'h0, "R3 burst word 0");

    // R3 shorter burst leaves upper registers
    run(32'h0105_0100, 32'h0);
    rd_chk(8'h20, 32'h1234_5678, "R3 single word");
    rd_chk(8'h34, 32'h1234_5678, "R3 upper register kept");
    clr_all();

    // R5 malformed requests
    run(32'h0104_0000, 32'h0);
    rd_chk(8'h84, 32'h10, "R5 count zero");
    clr_all();
    run(32'h0104_0900, 32'h0);
    rd_chk(8'h84, 32'h10, "R5 count nine");
    clr_all();
    run(32'h02FE_0300, 32'h0);
    rd_chk(8'h84, 32'h10, "R5 index plus count past end");
    clr_all();
    run(32'h0300_0002, 32'hFFFF_FFFF);
    rd_chk(8'h84, 32'h10, "R5 program index out of range");
    clr_all();
    run(32'h0104_0401, 32'h0);
    rd_chk(8'h84, 32'h10, "R5 opcode one");
    clr_all();
    run(32'h0104_0403, 32'h0);
    rd_chk(8'h84, 32'h10, "R5 opcode three");
    rd_chk(8'h20, 32'h1234_5678, "R5 read-back untouched");
    clr_all();

    // R5 boundary accepted
    run(32'h02F8_0800, 32'h0);
    rd_chk(8'h84, 32'h2, "R5 last legal burst accepted");
    clr_all();

    // R7 verify failure on defective cell
    run(32'h02F0_0002, 32'h8000_0001);
    rd_chk(8'h84, 32'h4, "R7 verify failure flagged");
    clr_all();
    run(32'h02F0_0100, 32'h0);
    rd_chk(8'h20, 32'h0000_0001, "R7 only good bit stored");
    clr_all();

    // R8 and R10: start and command change while busy
    bus_wr(8'h04, 32'h0104_0100);
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h04, 32'h0105_0100);
    bus_wr(8'h08, 32'h1);
    wait_idle();
    rd_chk(8'h20, 32'hA5A5_00FF, "R8 R10 first operation result");
    rd_chk(8'h84, 32'h2, "R8 no second operation");
    repeat (12) @(negedge clk);
    rd_chk(8'h84, 32'h2, "R8 still idle later");
    clr_all();

    // R9 clear on the completion edge: set wins
    bus_wr(8'h04, 32'h0104_0200);
    bus_wr(8'h08, 32'h1);
    repeat (2 * LAT - 1) @(negedge clk);
    bus_wr(8'h84, 32'h2);
    rd_chk(8'h84, 32'h2, "R9 set wins over clear");
    bus_wr(8'h84, 32'h4);
    rd_chk(8'h84, 32'h2, "R9 writing other bit keeps read done");
    bus_wr(8'h84, 32'h3);
    rd_chk(8'h84, 32'h0, "R9 clear read done, busy ignores write");

    repeat (4) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule